// File: doc/BRIEF.md
# Wake and Status-Change Register Block

This block holds the two 32-bit registers that report wake and interrupt conditions for a network function. The event-mask register keeps the software-chosen gating bits. The read-only present-state register shows four things: a general wake bit, a live interrupt flag, and two battery-voltage-detect indications. The block also drives one registered status-change line toward the host.

Three wake sources feed the general wake bit: link change, magic packet and filter match. Each source is captured in its own sticky flag, so a one-cycle pulse stays visible. Each flag is then gated by its own control. The link source passes when its enable is 1. The magic-packet source passes when its disable is 0. The filter source passes when the filter enable is 1. The general wake mask decides only whether the wake bit reaches the status-change line. It never alters what the present-state register reports. Software clears the sticky flags with per-source write-one-to-clear strobes and acknowledges interrupts with a one-cycle strobe.

Top module: `wake_status_regs`

## Requirements
- R1: After reset, the event-mask register reads 0, the present-state register reads 0 apart from the live battery-detect bits, and statusChange is 0.
- R2: Reads select the event-mask register when regSel=0 and the present-state register when regSel=1. In the event-mask register only bits 4 (general wake mask), 2 (battery-detect ready mask) and 1 (battery-detect write-protect mask) are writable. All other bits of both registers read 0, and writes to them are ignored.
- R3: The present-state register is read-only. A write with regSel=1 changes neither register.
- R4: Present-state bit 4 is the OR of three gated terms: (link sticky AND linkWakeEn), (magic sticky AND NOT magicWakeDis) and (filter sticky AND filterEn). The enables act at once, and a source pulse shows in bit 4 one clock after it is sampled.
- R5: Each source flag stays set until its clear strobe arrives: wakeClr[0] clears link, wakeClr[1] clears magic, wakeClr[2] clears filter. If a source pulse and its clear fall in the same cycle, the flag stays set.
- R6: Present-state bit 15 sets one clock after irqPendingIn is sampled high, whatever the mask holds. It clears one clock after an irqAck strobe, unless irqPendingIn is high in that same cycle.
- R7: The general wake mask has no effect on present-state bit 4.
- R8: statusChange is registered. One clock after sampling, it equals (present-state bit 4 AND mask bit 4) OR pmReqIn.
- R9: Present-state bit 2 follows bvdReadyIn and bit 1 follows bvdWpIn without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register select: 0 event mask, 1 present state |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| linkChangeIn | input | 1 | Link-change wake pulse |
| magicPktIn | input | 1 | Magic-packet wake pulse |
| filterMatchIn | input | 1 | Filter-match wake pulse |
| linkWakeEn | input | 1 | Link-change wake enable |
| magicWakeDis | input | 1 | Magic-packet wake disable |
| filterEn | input | 1 | Programmable filter enable |
| wakeClr | input | 3 | Write-one-to-clear strobes for the source flags |
| irqPendingIn | input | 1 | Interrupt pending from the function |
| irqAck | input | 1 | One-cycle interrupt acknowledge |
| bvdReadyIn | input | 1 | Battery-detect ready level |
| bvdWpIn | input | 1 | Battery-detect write-protect level |
| pmReqIn | input | 1 | Power-management request that drives statusChange alone |
| statusChange | output | 1 | Registered status-change line to the host |

## Verification
The hardest cases to reach are two same-cycle collisions: a source pulse arriving with its own clear strobe, and a new interrupt arriving with the acknowledge. Random stimulus hits these only rarely, so directed steps create each collision on purpose. Another hard case is a present-state wake bit that is 1 while the mask is 0; a directed step holds that state to show that the status line stays low. Around these steps, seeded random cycles toggle all pulses, enables, clears and writes at once. A bench model tracks the expected state for every cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_SRC    = 3;
  localparam int BIT_WP     = 1;
  localparam int BIT_RDY    = 2;
  localparam int BIT_GWAKE  = 4;
  localparam int BIT_IRQ    = 15;
  localparam logic [REG_W-1:0] MASK_WR_BITS =
    (REG_W'(1) << BIT_GWAKE) | (REG_W'(1) << BIT_RDY) | (REG_W'(1) << BIT_WP);
  localparam logic [REG_W-1:0] STATE_LIVE_BITS =
    (REG_W'(1) << BIT_IRQ) | MASK_WR_BITS;

  typedef enum logic { SEL_MASK = 1'b0, SEL_STATE = 1'b1 } regSel_e;

  typedef struct packed {
    logic               maskWr;
    logic [NUM_SRC-1:0] srcClr;
    logic               irqAck;
  } ctrlStrobes_t;
endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic               regSel,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] wakeClr,
  input  logic               irqAck,
  input  logic               linkWakeEn,
  input  logic               magicWakeDis,
  input  logic               filterEn,
  output ctrlStrobes_t       strobes,
  output logic [NUM_SRC-1:0] srcGate
);
  // Writes aimed at the present-state register are dropped here.
  always_comb begin
    strobes.maskWr = regWrEn && (regSel == SEL_MASK);
    strobes.srcClr = wakeClr;
    strobes.irqAck = irqAck;
  end

  // Normalise the three controls to active-high gates, in source order.
  assign srcGate = {filterEn, ~magicWakeDis, linkWakeEn};
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] srcGate,
  input  logic               irqPendingIn,
  input  logic               bvdReadyIn,
  input  logic               bvdWpIn,
  input  logic               pmReqIn,
  output logic [REG_W-1:0]   maskReg,
  output logic [REG_W-1:0]   stateWord,
  output logic               statusChange
);
  logic [NUM_SRC-1:0] srcSticky;
  logic               irqFlag;
  logic               genWake;

  // Sticky source capture: a new pulse beats a clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        srcSticky[i] <= 1'b0;
      else
        srcSticky[i] <= srcIn[i] | (srcSticky[i] & ~strobes.srcClr[i]);
    end
  end

  assign genWake = |(srcSticky & srcGate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      maskReg <= '0;
    else if (strobes.maskWr)
      maskReg <= regWrData & MASK_WR_BITS;
  end

  // Interrupt flag: pending sets it, an acknowledge clears it unless a new one arrives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqFlag <= 1'b0;
    else
      irqFlag <= irqPendingIn | (irqFlag & ~strobes.irqAck);
  end

  always_comb begin
    stateWord            = '0;
    stateWord[BIT_IRQ]   = irqFlag;
    stateWord[BIT_GWAKE] = genWake;
    stateWord[BIT_RDY]   = bvdReadyIn;
    stateWord[BIT_WP]    = bvdWpIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      statusChange <= 1'b0;
    else
      statusChange <= (genWake & maskReg[BIT_GWAKE]) | pmReqIn;
  end
endmodule

// File: rtl/wake_status_regs.sv
module wake_status_regs
  import wake_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               linkChangeIn,
  input  logic               magicPktIn,
  input  logic               filterMatchIn,
  input  logic               linkWakeEn,
  input  logic               magicWakeDis,
  input  logic               filterEn,
  input  logic [NUM_SRC-1:0] wakeClr,
  input  logic               irqPendingIn,
  input  logic               irqAck,
  input  logic               bvdReadyIn,
  input  logic               bvdWpIn,
  input  logic               pmReqIn,
  output logic               statusChange
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] srcGate;
  logic [REG_W-1:0]   maskReg;
  logic [REG_W-1:0]   stateWord;

  wake_ctrl u_ctrl (
    .regSel       (regSel),
    .regWrEn      (regWrEn),
    .wakeClr      (wakeClr),
    .irqAck       (irqAck),
    .linkWakeEn   (linkWakeEn),
    .magicWakeDis (magicWakeDis),
    .filterEn     (filterEn),
    .strobes      (strobes),
    .srcGate      (srcGate)
  );

  wake_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regWrData    (regWrData),
    .srcIn        ({filterMatchIn, magicPktIn, linkChangeIn}),
    .srcGate      (srcGate),
    .irqPendingIn (irqPendingIn),
    .bvdReadyIn   (bvdReadyIn),
    .bvdWpIn      (bvdWpIn),
    .pmReqIn      (pmReqIn),
    .maskReg      (maskReg),
    .stateWord    (stateWord),
    .statusChange (statusChange)
  );

  assign regRdData = (regSel == SEL_STATE) ? stateWord : maskReg;
endmodule

// File: rtl/wake_status_chk.sv
module wake_status_chk
  import wake_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] maskReg,
  input logic [REG_W-1:0] stateWord,
  input logic             statusChange,
  input logic             irqPendingIn,
  input logic             irqAck,
  input logic             pmReqIn,
  input logic             linkWakeEn,
  input logic             magicWakeDis,
  input logic             filterEn
);
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((maskReg & ~MASK_WR_BITS) == '0) && ((stateWord & ~STATE_LIVE_BITS) == '0));

  assert_gates_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!linkWakeEn && magicWakeDis && !filterEn) |-> !stateWord[BIT_GWAKE]);

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPendingIn |=> stateWord[BIT_IRQ]);

  assert_irq_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqPendingIn) |=> !stateWord[BIT_IRQ]);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateWord[BIT_IRQ] && !irqAck) |=> stateWord[BIT_IRQ]);

  assert_mask_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!maskReg[BIT_GWAKE] && !pmReqIn) |=> !statusChange);

  assert_wake_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateWord[BIT_GWAKE] && maskReg[BIT_GWAKE]) |=> statusChange);
endmodule

bind wake_status_regs wake_status_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .maskReg      (maskReg),
  .stateWord    (stateWord),
  .statusChange (statusChange),
  .irqPendingIn (irqPendingIn),
  .irqAck       (irqAck),
  .pmReqIn      (pmReqIn),
  .linkWakeEn   (linkWakeEn),
  .magicWakeDis (magicWakeDis),
  .filterEn     (filterEn)
);

// File: tb/tb_wake_status_regs.sv
module tb_wake_status_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        linkChangeIn = 0, magicPktIn = 0, filterMatchIn = 0;
  logic        linkWakeEn = 0, magicWakeDis = 0, filterEn = 0;
  logic [2:0]  wakeClr = '0;
  logic        irqPendingIn = 0, irqAck = 0;
  logic        bvdReadyIn = 0, bvdWpIn = 0, pmReqIn = 0;
  logic        statusChange;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  logic [31:0] mMask = '0;
  logic [2:0]  mSticky = '0;
  logic        mIrq = 0, mSc = 0;

  always #10 clk = ~clk;  // 50 MHz

  wake_status_regs dut (.*);

  function automatic logic genWakeOf(logic [2:0] s, logic le, logic md, logic fe);
    return (s[0] & le) | (s[1] & ~md) | (s[2] & fe);
  endfunction

  function automatic logic [31:0] expState();
    logic [31:0] w = '0;
    w[15] = mIrq;
    w[4]  = genWakeOf(mSticky, linkWakeEn, magicWakeDis, filterEn);
    w[2]  = bvdReadyIn;
    w[1]  = bvdWpIn;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readAll(string ctx);
    regSel = 1'b0; #1;
    chk({"R2 mask reg ", ctx}, regRdData, mMask);
    regSel = 1'b1; #1;
    chk({"R4 state reg ", ctx}, regRdData, expState());
    chk({"R8 statusChange ", ctx}, {31'b0, statusChange}, {31'b0, mSc});
  endtask

  // One clock: model next state from pre-edge inputs, then compare.
  task automatic step(string ctx);
    logic [31:0] nMask;
    logic [2:0]  nSticky;
    logic        nIrq, nSc;
    nMask   = (regWrEn && !regSel) ? (regWrData & 32'h0000_0016) : mMask;
    nSticky = {filterMatchIn, magicPktIn, linkChangeIn} | (mSticky & ~wakeClr);
    nIrq    = irqPendingIn | (mIrq & ~irqAck);
    nSc     = (genWakeOf(mSticky, linkWakeEn, magicWakeDis, filterEn) & mMask[4]) | pmReqIn;
    @(posedge clk); #2;
    mMask = nMask; mSticky = nSticky; mIrq = nIrq; mSc = nSc;
    regWrEn = 0; wakeClr = '0; irqAck = 0; irqPendingIn = 0;
    linkChangeIn = 0; magicPktIn = 0; filterMatchIn = 0;
    readAll(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2; readAll("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);

    // R2: all-ones write keeps only mask bits
    regSel = 0; regWrEn = 1; regWrData = 32'hFFFF_FFFF; step("R2 write ones");
    // R3: write aimed at present state is ignored
    regSel = 1; regWrEn = 1; regWrData = 32'h0000_0000; step("R3 state write");
    regSel = 1; regWrEn = 1; regWrData = 32'hFFFF_FFFF; step("R3 state write ones");

    // R4: link pulse gated off, then enabled
    linkChangeIn = 1; step("R4 link gated off");
    linkWakeEn = 1; #1; readAll("R4 enable acts at once");
    step("R8 wake reaches line");
    // R5: pulse and clear in same cycle keeps flag
    wakeClr = 3'b001; linkChangeIn = 1; step("R5 set beats clear");
    wakeClr = 3'b001; step("R5 clear link");
    // magic source passes when disable is low
    magicPktIn = 1; step("R4 magic");
    magicWakeDis = 1; #1; readAll("R4 magic disabled");
    filterMatchIn = 1; filterEn = 1; step("R4 filter");
    // R7: mask cleared, state bit stays, line falls
    regSel = 0; regWrEn = 1; regWrData = 32'h0; step("R7 mask off");
    step("R7 state unaffected by mask");
    pmReqIn = 1; step("R8 pm request alone");
    pmReqIn = 0; step("R8 pm request gone");

    // R6: interrupt set, hold, ack collision, ack
    irqPendingIn = 1; step("R6 irq set");
    step("R6 irq hold");
    irqAck = 1; irqPendingIn = 1; step("R6 ack with new irq");
    irqAck = 1; step("R6 ack clears");

    // R9: live battery bits
    bvdReadyIn = 1; #1; readAll("R9 ready");
    bvdWpIn = 1; bvdReadyIn = 0; #1; readAll("R9 wp");

    // seeded random mix
    for (int n = 0; n < 400; n++) begin
      regSel        = 1'($urandom);
      regWrEn       = ($urandom % 4) == 0;
      regWrData     = $urandom;
      linkChangeIn  = ($urandom % 5) == 0;
      magicPktIn    = ($urandom % 5) == 0;
      filterMatchIn = ($urandom % 5) == 0;
      linkWakeEn    = 1'($urandom);
      magicWakeDis  = 1'($urandom);
      filterEn      = 1'($urandom);
      wakeClr       = 3'($urandom);
      irqPendingIn  = ($urandom % 4) == 0;
      irqAck        = ($urandom % 3) == 0;
      bvdReadyIn    = 1'($urandom);
      bvdWpIn       = 1'($urandom);
      pmReqIn       = ($urandom % 8) == 0;
      step("random R5 R6");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule